// File: doc/BRIEF.md
# Nearest-Knot Table Address Generator

This block turns a four-parameter estimate (horizontal position, vertical position, spot diameter and electron count) into the byte address of one node in a precomputed lookup table held in external memory. The table is a regular four-dimensional grid. Each axis is described by a start value, a step and a knot count, and the knot count can differ from axis to axis. Each node holds 500 single-precision words: a 100-value model image and a 4x100 transfer matrix, 2000 bytes in all. No interpolation is done. The block rounds each parameter to its nearest knot and uses that node as if it were exact.

The four estimates are taken on a request. One shared sequential divider then processes the axes in turn, in the order horizontal, vertical, diameter, electron count. For each axis the block forms the rounded knot index, checks it against the knot count, and folds it into a linear node number. That number is scaled by the node size. The indices, the address and an out-of-range flag are held until the next request. On request, the block then walks the node word by word and emits one word address per cycle, which a memory front end can use to fetch it. Estimates and grid values share one fixed-point format of the caller's choosing. The grid configuration must stay stable while the block is busy.

The control is a state machine with these states. `ST_IDLE` waits for a request. `ST_PREP` forms the rounding numerator for the current axis. `ST_DIV` runs the divider for one quotient bit per cycle. `ST_ACCUM` range-checks the index and accumulates the node number. `ST_FINISH` scales the node number to a byte address. `ST_DONE` flags completion for one cycle. `ST_BURST` emits the word addresses. The transitions are as follows:
- `ST_IDLE` goes to `ST_PREP` on a request.
- `ST_PREP` always goes to `ST_DIV`.
- `ST_DIV` goes to `ST_ACCUM` after VAL_W+2 cycles.
- `ST_ACCUM` goes back to `ST_PREP` for the next axis, or to `ST_FINISH` after the fourth axis.
- `ST_FINISH` always goes to `ST_DONE`.
- `ST_DONE` goes to `ST_BURST` when a burst was asked for and every index is in range. Otherwise it goes to `ST_IDLE`.
- `ST_BURST` goes to `ST_IDLE` after its last word.

Top module: `knot_addr_gen`

## Requirements
- R1: While reset is held and after it, busy_o, done_o, burst_valid_o and range_err_o are 0, and node_addr_o and every index are 0.
- R2: For axis d, the index is floor((est - start)/step + 1/2), computed exactly as floor((2*(est - start) + step) / (2*step)). An estimate exactly halfway between two knots goes to the upper knot.
- R3: The node number is ((i0*k1 + i1)*k2 + i2)*k3 + i3. Axis 0 is horizontal, axis 1 vertical, axis 2 diameter and axis 3 electron count, and kd is the knot count of axis d. node_addr_o equals the node number times 2000.
- R4: An index below 0, or at or above its knot count, sets range_err_o. The index of that axis then reads 0 and node_addr_o is 0.
- R5: busy_o rises in the cycle after the accepting clock edge. done_o is high for exactly one cycle, 4*(VAL_W+4)+1 cycles after busy_o rises, which is 113 cycles at VAL_W=24.
- R6: A request that arrives while busy_o is high is ignored. It changes neither the result nor the timing.
- R7: When req_burst_i was high at acceptance and the node is in range, burst_valid_o is high for 500 consecutive cycles starting in the cycle after done_o. The addresses run from node_addr_o upward in steps of 4.
- R8: When any index is out of range, no burst is emitted, even if one was requested.
- R9: node_addr_o, idx_o and range_err_o hold their values from the done cycle until the next accepted request.
- R10: An axis with a single knot works as a fixed parameter. It yields index 0 when the estimate rounds to the start, and it is out of range otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request; accepted only when idle |
| req_burst_i | input | 1 | Ask for the word-address burst with this request |
| est_i | input | 4 x VAL_W | Signed estimates, axis 0 in the low slice |
| grid_start_i | input | 4 x VAL_W | Signed first-knot value per axis |
| grid_step_i | input | 4 x VAL_W | Positive knot spacing per axis |
| grid_knots_i | input | 4 x IDX_W | Knot count per axis |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| range_err_o | output | 1 | At least one axis fell outside its grid |
| node_addr_o | output | 4*IDX_W+11 | Byte address of the chosen node |
| idx_o | output | 4 x IDX_W | Per-axis knot indices |
| burst_valid_o | output | 1 | burst_addr_o carries a word address |
| burst_addr_o | output | 4*IDX_W+11 | Word address within the node |

## Verification
The bench goes after the halfway points and the points one unit below them, because a design that truncated instead of rounding, or that rounded ties down, would pick the wrong knot there. It probes both edges of the grid. The estimate just below the first knot's rounding window has a negative numerator, and a design that dropped the sign would wrap it to a huge but plausible index. An estimate that rounds to exactly the knot count catches an off-by-one in the bound compare. A collapsed axis and the all-maximum corner show whether the nesting order and the per-axis knot counts are used correctly. A swapped order gives a different node number there. The bench also sends a request in the middle of a computation, and asks for a burst on an out-of-range node. It checks that the burst stride and burst length stop exactly at the node's 500 words.

// File: rtl/nka_pkg.sv
package nka_pkg;

    localparam int NDIM = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV,
        ST_ACCUM,
        ST_FINISH,
        ST_DONE,
        ST_BURST
    } nka_state_e;

endpackage

// File: rtl/nka_round_div.sv
// Restoring divider: one quotient bit per step, MSB first.
module nka_round_div #(
    parameter int DW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [DW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic [DW-1:0] quo_o
);

    logic [DW-1:0] rem_q;
    logic [DW-1:0] num_q;
    logic [DW-1:0] quo_q;
    logic [DW:0]   rem_sh;
    logic          ge;

    assign rem_sh = {rem_q, num_q[DW-1]};
    assign ge     = rem_sh >= {1'b0, den_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            num_q <= '0;
            quo_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            num_q <= num_i;
            quo_q <= '0;
        end else if (step_i) begin
            rem_q <= ge ? DW'(rem_sh - {1'b0, den_i}) : rem_sh[DW-1:0];
            num_q <= {num_q[DW-2:0], 1'b0};
            quo_q <= {quo_q[DW-2:0], ge};
        end
    end

    assign quo_o = quo_q;

endmodule

// File: rtl/nka_burst_gen.sv
// Word-address walker across one table node.
module nka_burst_gen #(
    parameter int ADDR_W     = 43,
    parameter int NODE_WORDS = 500,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam int CNT_W = (NODE_WORDS > 1) ? $clog2(NODE_WORDS) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = cnt_q == CNT_W'(NODE_WORDS - 1);
    assign addr_o = base_i + ADDR_W'(cnt_q) * ADDR_W'(WORD_BYTES);

endmodule

// File: rtl/knot_addr_gen.sv
module knot_addr_gen
    import nka_pkg::*;
#(
    parameter int  VAL_W      = 24,
    parameter int  IDX_W      = 8,
    parameter int  NODE_BYTES = 2000,
    parameter int  WORD_BYTES = 4,
    localparam int LIN_W      = NDIM * IDX_W,
    localparam int ADDR_W     = LIN_W + $clog2(NODE_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid_i,
    input  logic                        req_burst_i,
    input  logic [NDIM-1:0][VAL_W-1:0]  est_i,
    input  logic [NDIM-1:0][VAL_W-1:0]  grid_start_i,
    input  logic [NDIM-1:0][VAL_W-1:0]  grid_step_i,
    input  logic [NDIM-1:0][IDX_W-1:0]  grid_knots_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        range_err_o,
    output logic [ADDR_W-1:0]           node_addr_o,
    output logic [NDIM-1:0][IDX_W-1:0]  idx_o,
    output logic                        burst_valid_o,
    output logic [ADDR_W-1:0]           burst_addr_o
);

    localparam int DW         = VAL_W + 2;
    localparam int NUM_W      = VAL_W + 3;
    localparam int DIM_W      = $clog2(NDIM);
    localparam int STEP_W     = $clog2(DW);
    localparam int NODE_WORDS = NODE_BYTES / WORD_BYTES;

    nka_state_e state_q, state_d;

    logic [DIM_W-1:0]              dim_q;
    logic [STEP_W-1:0]             step_q;
    logic [NDIM-1:0][VAL_W-1:0]    est_q;
    logic                          want_burst_q;
    logic                          neg_q;
    logic                          err_q;
    logic [LIN_W-1:0]              lin_q;
    logic [NDIM-1:0][IDX_W-1:0]    idx_q;
    logic [ADDR_W-1:0]             addr_q;

    logic signed [NUM_W-1:0]       est_x, start_x, step_x, num_s;
    logic [DW-1:0]                 den, div_num, quo;
    logic                          hit;
    logic                          burst_last;

    // Rounding numerator 2*(est-start)+step and denominator 2*step for the current axis.
    always_comb begin
        est_x   = NUM_W'($signed(est_q[dim_q]));
        start_x = NUM_W'($signed(grid_start_i[dim_q]));
        step_x  = NUM_W'(grid_step_i[dim_q]);
        num_s   = ((est_x - start_x) <<< 1) + step_x;
        div_num = num_s[NUM_W-1] ? '0 : num_s[DW-1:0];
        den     = {1'b0, grid_step_i[dim_q], 1'b0};
        hit     = !neg_q && (quo < DW'(grid_knots_i[dim_q]));
    end

    nka_round_div #(.DW(DW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (state_q == ST_PREP),
        .step_i (state_q == ST_DIV),
        .num_i  (div_num),
        .den_i  (den),
        .quo_o  (quo)
    );

    nka_burst_gen #(
        .ADDR_W     (ADDR_W),
        .NODE_WORDS (NODE_WORDS),
        .WORD_BYTES (WORD_BYTES)
    ) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_BURST),
        .base_i (addr_q),
        .addr_o (burst_addr_o),
        .last_o (burst_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid_i) state_d = ST_PREP;
            ST_PREP:   state_d = ST_DIV;
            ST_DIV:    if (step_q == STEP_W'(DW - 1)) state_d = ST_ACCUM;
            ST_ACCUM:  state_d = (dim_q == DIM_W'(NDIM - 1)) ? ST_FINISH : ST_PREP;
            ST_FINISH: state_d = ST_DONE;
            ST_DONE:   state_d = (want_burst_q && !err_q) ? ST_BURST : ST_IDLE;
            ST_BURST:  if (burst_last) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dim_q        <= '0;
            step_q       <= '0;
            est_q        <= '0;
            want_burst_q <= 1'b0;
            neg_q        <= 1'b0;
            err_q        <= 1'b0;
            lin_q        <= '0;
            idx_q        <= '0;
            addr_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid_i) begin
                    est_q        <= est_i;
                    want_burst_q <= req_burst_i;
                    dim_q        <= '0;
                    err_q        <= 1'b0;
                    lin_q        <= '0;
                end
                ST_PREP: begin
                    neg_q  <= num_s[NUM_W-1];
                    step_q <= '0;
                end
                ST_DIV:  step_q <= step_q + 1'b1;
                ST_ACCUM: begin
                    idx_q[dim_q] <= hit ? quo[IDX_W-1:0] : '0;
                    err_q        <= err_q | !hit;
                    lin_q        <= lin_q * LIN_W'(grid_knots_i[dim_q]) + LIN_W'(quo);
                    dim_q        <= dim_q + 1'b1;
                end
                ST_FINISH: addr_q <= err_q ? '0 : ADDR_W'(lin_q) * ADDR_W'(NODE_BYTES);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o        = state_q != ST_IDLE;
        done_o        = state_q == ST_DONE;
        burst_valid_o = state_q == ST_BURST;
        range_err_o   = err_q;
        node_addr_o   = addr_q;
        idx_o         = idx_q;
    end

endmodule

// File: rtl/knot_addr_gen_chk.sv
module knot_addr_gen_chk #(
    parameter int ADDR_W     = 43,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              range_err_o,
    input logic [ADDR_W-1:0] node_addr_o,
    input logic              burst_valid_o,
    input logic [ADDR_W-1:0] burst_addr_o
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R5
    AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && range_err_o) |-> node_addr_o == '0); // R4
    AST_BURST_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid_o && $past(burst_valid_o)) |-> burst_addr_o == $past(burst_addr_o) + ADDR_W'(WORD_BYTES)); // R7
    AST_BURST_FROM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_valid_o) |-> (burst_addr_o == node_addr_o) && $past(done_o)); // R7
    AST_BURST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid_o |-> !range_err_o); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> ($stable(node_addr_o) && $stable(range_err_o))); // R9

endmodule

bind knot_addr_gen knot_addr_gen_chk #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .range_err_o   (range_err_o),
    .node_addr_o   (node_addr_o),
    .burst_valid_o (burst_valid_o),
    .burst_addr_o  (burst_addr_o)
);

// File: tb/test_knot_addr_gen.sv
module test_knot_addr_gen;

    localparam int VAL_W = 24;
    localparam int IDX_W = 8;
    localparam int NB    = 2000;
    localparam int WB    = 4;
    localparam int NW    = NB / WB;
    localparam int AW    = 4 * IDX_W + $clog2(NB);
    localparam int LAT   = 4 * (VAL_W + 4) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_burst = 1'b0;
    logic [3:0][VAL_W-1:0] est = '0;
    logic [3:0][VAL_W-1:0] g_start = '0;
    logic [3:0][VAL_W-1:0] g_step = '0;
    logic [3:0][IDX_W-1:0] g_knots = '0;
    logic busy_o, done_o, range_err_o, burst_valid_o;
    logic [AW-1:0] node_addr_o, burst_addr_o;
    logic [3:0][IDX_W-1:0] idx_o;

    always #2 clk = ~clk;

    knot_addr_gen i_knot_addr_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .req_burst_i   (req_burst),
        .est_i         (est),
        .grid_start_i  (g_start),
        .grid_step_i   (g_step),
        .grid_knots_i  (g_knots),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .range_err_o   (range_err_o),
        .node_addr_o   (node_addr_o),
        .idx_o         (idx_o),
        .burst_valid_o (burst_valid_o),
        .burst_addr_o  (burst_addr_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int burst_seen = 0;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Behavioural reference model: phase counter since acceptance.
    int     ph = -1;
    longint p_addr = 0, h_addr = 0;
    int     p_idx[4], h_idx[4];
    bit     p_err = 0, h_err = 0, p_burst = 0;

    always @(posedge clk) begin : model
        longint num, q, lin;
        int last;
        if (!rst_n) begin
            ph = -1; h_addr = 0; h_err = 0;
            for (int d = 0; d < 4; d++) h_idx[d] = 0;
        end else if (ph < 0) begin
            if (req_valid) begin
                p_err = 0; lin = 0; p_burst = req_burst;
                for (int d = 0; d < 4; d++) begin
                    num = 2 * (longint'($signed(est[d])) - longint'($signed(g_start[d]))) + longint'(g_step[d]);
                    q = (num < 0) ? -1 : num / (2 * longint'(g_step[d]));
                    if (q >= 0 && q < longint'(g_knots[d])) p_idx[d] = int'(q);
                    else begin p_idx[d] = 0; p_err = 1; end
                    lin = lin * longint'(g_knots[d]) + q;
                end
                p_addr = p_err ? 0 : lin * NB;
                ph = 1;
            end
        end else begin
            ph = ph + 1;
            if (ph == LAT + 1) begin
                h_addr = p_addr; h_err = p_err;
                for (int d = 0; d < 4; d++) h_idx[d] = p_idx[d];
            end
            last = (p_burst && !p_err) ? LAT + 1 + NW : LAT + 1;
            if (ph > last) ph = -1;
        end
    end

    always @(negedge clk) begin
        string t;
        if (rst_n && !finished) begin
            chk("R5", "busy", longint'(busy_o), longint'(ph >= 1));
            chk("R5", "done", longint'(done_o), longint'(ph == LAT + 1));
            chk((p_burst && p_err) ? "R8" : "R7", "burst_valid", longint'(burst_valid_o), longint'(ph >= LAT + 2));
            if (burst_valid_o) burst_seen++;
            if (ph >= LAT + 2)
                chk("R7", "burst_addr", longint'(burst_addr_o), h_addr + longint'(WB * (ph - LAT - 2)));
            if (ph < 0 || ph >= LAT + 1) begin
                chk((ph < 0) ? "R9" : "R3", "node_addr", longint'(node_addr_o), h_addr);
                chk((ph < 0) ? "R9" : "R4", "range_err", longint'(range_err_o), longint'(h_err));
                for (int d = 0; d < 4; d++) begin
                    t = (ph < 0) ? "R9" : "R2";
                    chk(t, "idx", longint'(idx_o[d]), longint'(h_idx[d]));
                end
            end
        end
    end

    task automatic wait_idle();
        int n = 0;
        while (busy_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_req(longint ex, longint ey, longint ed, longint en, bit b,
                           string tag, longint exp_addr, bit exp_err);
        @(negedge clk);
        est[0] = VAL_W'(ex); est[1] = VAL_W'(ey); est[2] = VAL_W'(ed); est[3] = VAL_W'(en);
        req_burst = b;
        req_valid = 1'b1;
        burst_seen = 0;
        @(negedge clk);
        req_valid = 1'b0;
        req_burst = 1'b0;
        wait_idle();
        chk(tag, "result addr", longint'(node_addr_o), exp_addr);
        chk(tag, "result err", longint'(range_err_o), longint'(exp_err));
    endtask

    initial begin
        g_start[0] = 24'd4500;   g_step[0] = 24'd90;   g_knots[0] = 8'd12;
        g_start[1] = 24'd4500;   g_step[1] = 24'd90;   g_knots[1] = 8'd12;
        g_start[2] = 24'd380000; g_step[2] = 24'd5000; g_knots[2] = 8'd11;
        g_start[3] = 24'd0;      g_step[3] = 24'd500;  g_knots[3] = 8'd21;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", longint'(busy_o), 0);
        chk("R1", "done", longint'(done_o), 0);
        chk("R1", "burst_valid", longint'(burst_valid_o), 0);
        chk("R1", "node_addr", longint'(node_addr_o), 0);
        chk("R1", "range_err", longint'(range_err_o), 0);
        chk("R1", "idx", longint'(idx_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: interior point, indices 6,0,5,7 -> node 16744
        run_req(5000, 4500, 405000, 3700, 0, "R3", 64'd33488000, 0);
        // R2: exact halfway points round up; just below rounds down -> 1,0,1,1
        run_req(4545, 4544, 382500, 250, 0, "R2", 64'd5588000, 0);
        chk("R2", "tie index x", longint'(idx_o[0]), 1);
        chk("R2", "below-tie index y", longint'(idx_o[1]), 0);
        // R3: all-maximum corner -> node 33263
        run_req(5534, 5490, 430000, 10000, 0, "R3", 64'd66526000, 0);
        chk("R3", "corner idx N", longint'(idx_o[3]), 20);
        // R4: rounds to knot count on x
        run_req(5535, 4500, 405000, 3700, 0, "R4", 0, 1);
        chk("R4", "out-of-range idx x", longint'(idx_o[0]), 0);
        // R3: lowest node in range
        run_req(4455, 4500, 380000, 0, 0, "R3", 0, 0);
        // R4: negative numerator on y
        run_req(4455, 4454, 380000, 0, 0, "R4", 0, 1);
        // R7: burst on in-range node
        run_req(5000, 4500, 405000, 3700, 1, "R7", 64'd33488000, 0);
        chk("R7", "burst length", longint'(burst_seen), NW);
        // R8: burst requested on out-of-range node
        run_req(5535, 4500, 405000, 3700, 1, "R8", 0, 1);
        chk("R8", "burst length", longint'(burst_seen), 0);

        // R6: second request while busy is ignored
        @(negedge clk);
        est[0] = 24'd5000; est[1] = 24'd4500; est[2] = 24'd405000; est[3] = 24'd3700;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        est[0] = 24'd5534; est[1] = 24'd5490; est[2] = 24'd430000; est[3] = 24'd10000;
        req_valid = 1'b1; req_burst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_burst = 1'b0;
        wait_idle();
        chk("R6", "addr after ignored request", longint'(node_addr_o), 64'd33488000);
        repeat (3) @(negedge clk);
        chk("R6", "no extra run", longint'(busy_o), 0);

        // R9: held while idle
        repeat (20) @(negedge clk);
        chk("R9", "held addr", longint'(node_addr_o), 64'd33488000);

        // R10: collapsed diameter axis
        g_start[2] = 24'd378000; g_step[2] = 24'd5000; g_knots[2] = 8'd1;
        run_req(5000, 4500, 379000, 3700, 0, "R10", 64'd3038000, 0);
        run_req(5000, 4500, 381000, 3700, 0, "R10", 0, 1);

        repeat (5) @(negedge clk);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

endmodule